// File: doc/BRIEF.md
# Link Reset Request/Acknowledge Controller

This block runs the in-band reset handshake of a serial fronthaul link. One reset bit travels in every hyperframe, in bit 0 of control word Z.130.0. The same bit carries two meanings. On the downlink it is a request from the master to the slave. On the uplink it is the acknowledge from the slave back to the master. Framing logic outside the block supplies a one-cycle hyperframe strobe and the received reset bit. It inserts the block's transmit bit into the outgoing hyperframe.

In the master role, a trigger starts a request. The trigger comes either from software (an enable bit together with a force bit) or from hardware (a hardware enable bit together with a hardware reset input). The request is sent every hyperframe until one of two things happens. Either the trigger is withdrawn, which aborts the request. Or the acknowledge from the far end passes a persistence filter, which completes the request. Completion sets a sticky flag that a read pulse clears.

In the slave role, the same filter qualifies an incoming request, and a confirmed request raises a status flag for the application. The slave sends the acknowledge only while its own trigger condition also holds. In both roles the hardware enable bit takes priority over the software enable bit.

Top module: `link_rst_handshake`

States:
- `ST_IDLE`: nothing is being sent.
- `ST_REQ`: master only, request is being sent.
- `ST_DONE`: master only, completed while the trigger is still held.
- `ST_ACK`: slave only, acknowledge is being sent.

Transitions (all taken on a strobe):
- IDLE→REQ when the master's trigger holds.
- REQ→IDLE on abort.
- REQ→DONE on completion while the trigger is still held.
- REQ→IDLE on completion while the trigger has dropped.
- DONE→IDLE when the trigger drops.
- IDLE→ACK when the slave's request is confirmed and its trigger holds.
- ACK→IDLE when either of those two conditions is lost.

## Requirements
- R1: A synchronous reset (`rst`=1) clears `tx_rst_bit`, `rst_detected` and `req_done` to 0 and returns the state machine to idle.
- R2: `tx_rst_bit`, `rst_detected`, the state and the persistence count change only on a clock edge where `hf_strobe`=1. The one exception is that `req_done` may also be cleared by `done_rd`.
- R3: A received reset bit is confirmed on the tenth consecutive strobe that sees `rx_rst_bit`=1, counting that strobe. Any strobe with `rx_rst_bit`=0 restarts the count from zero and removes confirmation.
- R4: The trigger is computed as follows. When `ctl_hw_en`=0, the trigger is `ctl_sw_en` AND `ctl_sw_force`. When `ctl_hw_en`=1, the trigger is `hw_rst_in`. In the master role (`role_master`=1), an active trigger at a strobe in idle starts sending `tx_rst_bit`=1 from that strobe.
- R5: When `ctl_hw_en`=1, the software enable and force bits have no effect on the trigger, in both roles.
- R6: In the master role, a strobe on which the trigger is inactive, while no acknowledge is confirmed, aborts the request. The abort sets `tx_rst_bit`=0 and leaves `req_done` unchanged.
- R7: A confirmed acknowledge (R3) while requesting completes the request. On that strobe `tx_rst_bit` becomes 0 and `req_done` becomes 1. Completion takes precedence over a simultaneous loss of the trigger. A new request starts only after the trigger has been seen inactive at a strobe.
- R8: `req_done` is sticky and is cleared by `done_rd`=1 on any clock edge. If completion and `done_rd` fall on the same edge, `req_done` is 1 afterwards.
- R9: In the slave role (`role_master`=0), `rst_detected` equals the confirmation of R3, regardless of the trigger. `rst_detected` stays 0 in the master role.
- R10: In the slave role, `tx_rst_bit` is 1 after a strobe exactly when the received bit is confirmed and the slave's trigger (R4) is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| role_master | input | 1 | 1 = master role, 0 = slave role; static while running |
| hf_strobe | input | 1 | One-cycle pulse per received hyperframe |
| rx_rst_bit | input | 1 | Reset bit extracted from the received hyperframe |
| hw_rst_in | input | 1 | Hardware reset trigger input |
| ctl_sw_en | input | 1 | Software trigger enable |
| ctl_sw_force | input | 1 | Software trigger force |
| ctl_hw_en | input | 1 | Hardware trigger enable; overrides software enable |
| done_rd | input | 1 | Read pulse that clears `req_done` |
| tx_rst_bit | output | 1 | Reset bit for the outgoing hyperframe |
| rst_detected | output | 1 | Slave: confirmed incoming reset request |
| req_done | output | 1 | Master: sticky request-completed flag |

## Verification
Two events can fall on the same clock edge. The first pair is completion and abort: the tenth confirming acknowledge strobe arrives with the software force bit already dropped. The outcome is judged as completion, with `req_done`=1 and `tx_rst_bit`=0. The second pair is completion and the read-clear: that tenth strobe is driven in the very cycle of a `done_rd` pulse, and the flag must survive. A behavioural model in the bench predicts every output on every clock, and both corners are also checked against fixed expected values.

// File: rtl/lrh_pkg.sv
package lrh_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_DONE = 2'd2,
        ST_ACK  = 2'd3
    } lrh_state_e;

endpackage

// File: rtl/lrh_trigger_sel.sv
module lrh_trigger_sel (
    input  logic sw_en,
    input  logic sw_force,
    input  logic hw_en,
    input  logic hw_in,
    output logic trig
);
    // hardware enable wins; software enable is then ignored
    always_comb begin
        if (hw_en) trig = hw_in;
        else       trig = sw_en & sw_force;
    end
endmodule

// File: rtl/lrh_persist_filter.sv
module lrh_persist_filter #(
    parameter int THRESH = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    input  logic bit_in,
    output logic conf_d,
    output logic conf_q
);
    localparam int CW = $clog2(THRESH + 1);
    localparam logic [CW-1:0] LIM  = CW'(THRESH);
    localparam logic [CW-1:0] LIM1 = CW'(THRESH - 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        if (!bit_in)          cnt_d = '0;
        else if (cnt_q < LIM) cnt_d = cnt_q + 1'b1;
        else                  cnt_d = cnt_q;
        conf_d = bit_in && (cnt_q >= LIM1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            conf_q <= 1'b0;
        end else if (strobe) begin
            cnt_q  <= cnt_d;
            conf_q <= conf_d;
        end
    end
endmodule

// File: rtl/lrh_fsm.sv
module lrh_fsm
    import lrh_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    input  logic role_master,
    input  logic trig,
    input  logic conf,
    input  logic done_rd,
    output logic tx_bit,
    output logic done
);
    lrh_state_e st_q, st_d;
    logic       complete;

    always_comb begin
        st_d     = st_q;
        complete = 1'b0;
        if (strobe) begin
            unique case (st_q)
                ST_IDLE: begin
                    if (role_master) begin
                        if (trig) st_d = ST_REQ;
                    end else if (conf && trig) begin
                        st_d = ST_ACK;
                    end
                end
                ST_REQ: begin
                    if (conf) begin
                        complete = 1'b1;
                        st_d     = trig ? ST_DONE : ST_IDLE;
                    end else if (!trig) begin
                        st_d = ST_IDLE;
                    end
                end
                ST_DONE: begin
                    if (!trig) st_d = ST_IDLE;
                end
                ST_ACK: begin
                    if (!(conf && trig)) st_d = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_bit <= 1'b0;
            done   <= 1'b0;
        end else begin
            if (strobe) tx_bit <= (st_d == ST_REQ) || (st_d == ST_ACK);
            if (complete)     done <= 1'b1;
            else if (done_rd) done <= 1'b0;
        end
    end
endmodule

// File: rtl/link_rst_handshake.sv
module link_rst_handshake #(
    parameter int HF_THRESH = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic role_master,
    input  logic hf_strobe,
    input  logic rx_rst_bit,
    input  logic hw_rst_in,
    input  logic ctl_sw_en,
    input  logic ctl_sw_force,
    input  logic ctl_hw_en,
    input  logic done_rd,
    output logic tx_rst_bit,
    output logic rst_detected,
    output logic req_done
);
    logic trig, conf_now, conf_reg;

    lrh_trigger_sel u_trig (
        .sw_en    (ctl_sw_en),
        .sw_force (ctl_sw_force),
        .hw_en    (ctl_hw_en),
        .hw_in    (hw_rst_in),
        .trig     (trig)
    );

    lrh_persist_filter #(.THRESH(HF_THRESH)) u_filt (
        .clk    (clk),
        .rst    (rst),
        .strobe (hf_strobe),
        .bit_in (rx_rst_bit),
        .conf_d (conf_now),
        .conf_q (conf_reg)
    );

    lrh_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .strobe      (hf_strobe),
        .role_master (role_master),
        .trig        (trig),
        .conf        (conf_now),
        .done_rd     (done_rd),
        .tx_bit      (tx_rst_bit),
        .done        (req_done)
    );

    assign rst_detected = conf_reg & ~role_master;
endmodule

// File: rtl/lrh_checker.sv
module lrh_checker (
    input logic clk,
    input logic rst,
    input logic role_master,
    input logic hf_strobe,
    input logic rx_rst_bit,
    input logic hw_rst_in,
    input logic ctl_hw_en,
    input logic done_rd,
    input logic tx_rst_bit,
    input logic rst_detected,
    input logic req_done
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!tx_rst_bit && !rst_detected && !req_done));

    // R2
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !hf_strobe |=> $stable(tx_rst_bit));

    // R2
    det_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!hf_strobe && !$past(rst)) |=> $stable(rst_detected));

    // R3
    det_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_detected) |-> $past(hf_strobe && rx_rst_bit));

    // R5
    hw_priority_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_hw_en && !hw_rst_in && hf_strobe) |=> !tx_rst_bit);

    // R7
    done_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(req_done) |-> $past(hf_strobe && role_master && rx_rst_bit));

    // R8
    done_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (done_rd && !hf_strobe) |=> !req_done);

    // R10
    slave_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (!role_master && tx_rst_bit) |-> rst_detected);
endmodule

bind link_rst_handshake lrh_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .role_master  (role_master),
    .hf_strobe    (hf_strobe),
    .rx_rst_bit   (rx_rst_bit),
    .hw_rst_in    (hw_rst_in),
    .ctl_hw_en    (ctl_hw_en),
    .done_rd      (done_rd),
    .tx_rst_bit   (tx_rst_bit),
    .rst_detected (rst_detected),
    .req_done     (req_done)
);

// File: tb/link_rst_handshake_bench.sv
`timescale 1ns/1ps
module link_rst_handshake_bench;
    logic clk = 1'b0;
    logic rst = 1'b1, role_master = 1'b1, hf_strobe = 1'b0, rx_rst_bit = 1'b0;
    logic hw_rst_in = 1'b0, ctl_sw_en = 1'b0, ctl_sw_force = 1'b0, ctl_hw_en = 1'b0;
    logic done_rd = 1'b0;
    logic tx_rst_bit, rst_detected, req_done;

    int n_checks = 0, n_fail = 0, cycles = 0;

    always #10 clk = ~clk;

    link_rst_handshake u_link_rst_handshake (
        .clk(clk), .rst(rst), .role_master(role_master), .hf_strobe(hf_strobe),
        .rx_rst_bit(rx_rst_bit), .hw_rst_in(hw_rst_in), .ctl_sw_en(ctl_sw_en),
        .ctl_sw_force(ctl_sw_force), .ctl_hw_en(ctl_hw_en), .done_rd(done_rd),
        .tx_rst_bit(tx_rst_bit), .rst_detected(rst_detected), .req_done(req_done)
    );

    // behavioural reference model
    int m_cnt = 0, m_st = 0;
    bit m_tx = 0, m_det = 0, m_done = 0;
    always @(posedge clk) begin
        bit trig, conf;
        if (rst) begin
            m_cnt = 0; m_st = 0; m_tx = 0; m_det = 0; m_done = 0;
        end else begin
            if (done_rd) m_done = 0;
            if (hf_strobe) begin
                trig  = ctl_hw_en ? hw_rst_in : (ctl_sw_en && ctl_sw_force);
                m_cnt = rx_rst_bit ? ((m_cnt < 10) ? m_cnt + 1 : 10) : 0;
                conf  = (m_cnt == 10);
                m_det = conf && !role_master;
                if (role_master) begin
                    if (m_st == 0) begin
                        if (trig) m_st = 1;
                    end else if (m_st == 1) begin
                        if (conf) begin m_done = 1; m_st = trig ? 2 : 0; end
                        else if (!trig) m_st = 0;
                    end else if (!trig) m_st = 0;
                    m_tx = (m_st == 1);
                end else begin
                    m_st = (conf && trig) ? 3 : 0;
                    m_tx = (m_st == 3);
                end
            end
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            chk("R2 model tx_rst_bit", tx_rst_bit, m_tx);
            chk("R9 model rst_detected", rst_detected, m_det);
            chk("R8 model req_done", req_done, m_done);
        end
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic hf(input logic rx, input logic rd = 1'b0);
        @(negedge clk);
        hf_strobe = 1'b1; rx_rst_bit = rx; done_rd = rd;
        @(negedge clk);
        hf_strobe = 1'b0; done_rd = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic hf_n(input int n, input logic rx);
        for (int i = 0; i < n; i++) hf(rx);
    endtask

    task automatic rd_pulse();
        @(negedge clk); done_rd = 1'b1;
        @(negedge clk); done_rd = 1'b0;
    endtask

    task automatic do_reset(input logic role);
        @(negedge clk); rst = 1'b1; role_master = role;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    initial begin
        do_reset(1'b1);
        chk("R1 tx after reset", tx_rst_bit, 1'b0);
        chk("R1 detected after reset", rst_detected, 1'b0);
        chk("R1 done after reset", req_done, 1'b0);

        // software request, master
        ctl_sw_en = 1; ctl_sw_force = 1;
        @(negedge clk); @(negedge clk);
        chk("R2 no strobe no tx", tx_rst_bit, 1'b0);
        hf(0);
        chk("R4 sw request tx", tx_rst_bit, 1'b1);
        // nine acks, then a gap restarts the count
        hf_n(9, 1); hf(0);
        chk("R3 gap restarts, still requesting", tx_rst_bit, 1'b1);
        hf_n(9, 1);
        chk("R3 nine acks not enough", req_done, 1'b0);
        hf(1);
        chk("R7 tx cleared on completion", tx_rst_bit, 1'b0);
        chk("R7 done set", req_done, 1'b1);
        chk("R9 no detect in master", rst_detected, 1'b0);
        hf_n(2, 0);
        chk("R7 no re-request while held", tx_rst_bit, 1'b0);
        rd_pulse();
        chk("R8 done cleared by read", req_done, 1'b0);
        ctl_sw_force = 0; hf(0);
        ctl_sw_force = 1; hf(0);
        chk("R7 re-request after drop", tx_rst_bit, 1'b1);
        // abort via software enable
        ctl_sw_en = 0; hf(0);
        chk("R6 abort clears tx", tx_rst_bit, 1'b0);
        chk("R6 abort no done", req_done, 1'b0);

        // hardware priority
        ctl_sw_en = 1; ctl_sw_force = 1; ctl_hw_en = 1; hw_rst_in = 0; hf(0);
        chk("R5 hw enable masks sw", tx_rst_bit, 1'b0);
        hw_rst_in = 1; hf(0);
        chk("R4 hw request tx", tx_rst_bit, 1'b1);
        ctl_sw_en = 0; hf(0);
        chk("R5 sw enable ignored under hw", tx_rst_bit, 1'b1);
        ctl_hw_en = 0; hf(0);
        chk("R6 hw abort", tx_rst_bit, 1'b0);

        // completion coincides with abort
        ctl_sw_en = 1; hf(0);
        hf_n(9, 1);
        ctl_sw_force = 0; hf(1);
        chk("R7 completion beats abort done", req_done, 1'b1);
        chk("R7 completion beats abort tx", tx_rst_bit, 1'b0);
        rd_pulse();
        // completion coincides with read clear
        ctl_sw_force = 1; hf(0);
        hf_n(9, 1); hf(1, 1'b1);
        chk("R8 set wins over read", req_done, 1'b1);

        // slave role
        ctl_sw_en = 0; ctl_sw_force = 0; ctl_hw_en = 0; hw_rst_in = 0;
        do_reset(1'b0);
        hf_n(9, 1);
        chk("R3 slave nine not confirmed", rst_detected, 1'b0);
        hf(1);
        chk("R9 detected without trigger", rst_detected, 1'b1);
        chk("R10 no ack without trigger", tx_rst_bit, 1'b0);
        ctl_sw_en = 1; ctl_sw_force = 1; hf(1);
        chk("R10 ack sent", tx_rst_bit, 1'b1);
        hf(0);
        chk("R9 detect drops on clear bit", rst_detected, 1'b0);
        chk("R10 ack drops", tx_rst_bit, 1'b0);
        ctl_hw_en = 1; hf_n(10, 1);
        chk("R5 slave hw masks sw ack", tx_rst_bit, 1'b0);
        hw_rst_in = 1; hf(1);
        chk("R10 slave hw ack", tx_rst_bit, 1'b1);

        do_reset(1'b0);
        chk("R1 reset clears slave ack", tx_rst_bit, 1'b0);
        chk("R1 reset clears detect", rst_detected, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule